// File: doc/BRIEF.md
# Dual-Die Interleaved Flash Page Program Sequencer

This block sits on the host side of a register-mapped NAND-style flash device that holds two dies in one package. The device is reached over a 16-bit synchronous register port. The requesting logic hands the block one command: the die that goes first, a block address, a starting page and a page count. The block then programs that many pages on both dies, with the dies taking turns. Page data comes from a valid/ready word stream and is copied into the device data buffer through the same register port.

Work is done in pairs. For each page, the first die is loaded and commanded, then the second die is loaded and commanded. A page that is not the last one uses the cache-program command; the last page uses the final-program command on both dies. After each pair, the block selects each die in turn. It polls the interrupt register until the device reports ready, then reads the controller status word. The operation ends on success, on a program error (current or previous operation), or when a programmable poll limit runs out. On the ending cycle the block pulses `res_done` together with an error code, the die, the page and the raw status or interrupt word.

The register port has fixed timing. `bus_en` with `bus_we` high is a write in that cycle. `bus_en` with `bus_we` low is a read, and the device returns the data on `bus_rdata` in the next cycle.

Top module: `flash_il_prog_seq`

## Requirements
- R1: While reset is held and right after it, `cmd_ready` is 1 and `res_done`, `din_ready` and `bus_en` are 0.
- R2: Each die's page load starts with four writes in this order: F100h = {die in bit 15, block in bits 9:0}, F101h = {die in bit 15, zeros}, F107h = {page in bits 7:2, sector bits 1:0 = 00}, F200h = 0800h.
- R3: Next come exactly PAGE_WORDS data writes to addresses BUF_BASE+0 upward. Each write carries the stream words in arrival order. `din_ready` is high only during this phase, and the data-buffer select write always comes before any data write.
- R4: After each die's data, a write to F220h carries 007Fh for every pair except the last and 0080h for the last pair. A page count of 0 acts as 1.
- R5: Within a pair, the die given with the command goes first and the other die second, both on the same page. Pair k uses the first page plus k.
- R6: Both dies of a pair are always commanded before any check starts, so every ending (success, error or timeout) follows an even number of program commands.
- R7: After each pair, for the first die and then the second, the block writes F100h to select the die. It then reads F241h until the value 8040h is returned, and then reads F240h once.
- R8: If a status read has bit 2 set, the operation ends with code 2 (previous-operation error). Otherwise, if bit 10 or bit 4 is set, it ends with code 1. In both cases the block reports the checked die, the pair's page and the status word, and stops at once.
- R9: A not-ready interrupt read that brings the count of not-ready reads in one check to max(poll_limit,1) ends the operation with code 3. The last interrupt value goes in the status field.
- R10: When every check passes, the operation ends with code 0 and the last status word, after the checks of the last pair.
- R11: `res_done` is a one-cycle pulse, and `cmd_ready` is low from command acceptance until after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| cmd_die | input | 1 | Die programmed first in each pair |
| cmd_block | input | BLK_W | Flash block address |
| cmd_page | input | PG_W | First page |
| cmd_count | input | PG_W+1 | Pages per die (0 acts as 1) |
| poll_limit | input | TMO_W | Not-ready interrupt reads allowed per check |
| din_valid | input | 1 | Stream word valid |
| din_ready | output | 1 | Stream word taken |
| din_data | input | 16 | Stream word |
| bus_en | output | 1 | Register access strobe |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register or buffer address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, one cycle after a read strobe |
| res_done | output | 1 | End-of-operation pulse |
| res_code | output | 2 | 0 ok, 1 program error, 2 previous error, 3 timeout |
| res_die | output | 1 | Die being checked at the end |
| res_page | output | PG_W | Page of the pair being checked at the end |
| res_status | output | 16 | Last status or interrupt word read |

## Verification
The hardest situation to reach is an error on the second die of a middle pair. Reaching it needs several full cache pairs to complete cleanly first, and then a fault that only that die reports on exactly that check. The bench device model counts status reads per die and returns the chosen fault word only on the selected check number. It also holds the interrupt not-ready for a chosen number of reads, which drives both the polling loop and the timeout path. The complete register trace is compared with a trace the bench builds from the requirements.

// File: rtl/fseq_pkg.sv
// Package: register addresses, command codes and shared types of the
// dual-die program sequencer. Assumes a 16-bit register-mapped device.
package fseq_pkg;
    localparam logic [15:0] A_DIE_BLK = 16'hF100;
    localparam logic [15:0] A_BUF_SEL = 16'hF101;
    localparam logic [15:0] A_PG_ADDR = 16'hF107;
    localparam logic [15:0] A_BSC     = 16'hF200;
    localparam logic [15:0] A_CMD     = 16'hF220;
    localparam logic [15:0] A_CTL_ST  = 16'hF240;
    localparam logic [15:0] A_INT     = 16'hF241;

    localparam logic [15:0] V_BSC     = 16'h0800;
    localparam logic [15:0] V_CACHE   = 16'h007F;
    localparam logic [15:0] V_FINAL   = 16'h0080;
    localparam logic [15:0] V_READY   = 16'h8040;

    localparam int ST_PREV_BIT = 2;
    localparam int ST_CUR_BIT  = 4;
    localparam int ST_PGM_BIT  = 10;

    typedef enum logic [1:0] {
        E_OK   = 2'd0,
        E_PROG = 2'd1,
        E_PREV = 2'd2,
        E_TMO  = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL, S_BSEL, S_PADDR, S_BSC, S_DATA, S_CMD,
        S_CSEL, S_IRD, S_IWT, S_SRD, S_SWT, S_FIN
    } state_e;
endpackage

// File: rtl/fseq_word_ctr.sv
// Page word counter: gives the word index inside the device buffer and
// flags the last word. Assumes clr and adv are never high together.
module fseq_word_ctr #(
    parameter int WORDS = 2048,
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          last
);
    // Step the index once for each accepted word, restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) idx <= '0;
        else if (adv)      idx <= idx + 1'b1;
    end

    assign last = (idx == IW'(WORDS - 1));
endmodule

// File: rtl/fseq_poll_timer.sv
// Poll timeout counter: counts not-ready interrupt reads within one check
// and signals expiry on the read that reaches max(limit,1).
module fseq_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Count not-ready reads, saturating, cleared at the start of each check.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt <= '0;
        else if (tick && ~&cnt)     cnt <= cnt + 1'b1;
    end

    assign expire = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/fseq_status_eval.sv
// Status classifier: maps a controller status word to an error flag and
// code. A previous-operation error takes priority over a current one.
module fseq_status_eval
    import fseq_pkg::*;
(
    input  logic [15:0] st,
    output logic        is_err,
    output err_e        code
);
    // Decide the error class from the three error bits.
    always_comb begin
        if (st[ST_PREV_BIT])                     code = E_PREV;
        else if (st[ST_PGM_BIT] || st[ST_CUR_BIT]) code = E_PROG;
        else                                     code = E_OK;
        is_err = (code != E_OK);
    end
endmodule

// File: rtl/flash_il_prog_seq.sv
// Dual-die interleaved program sequencer. Loads and commands both dies for
// each page (cache program except on the last page), then polls each die's
// interrupt and status words. Assumes a fixed one-cycle read latency on the
// register port.
module flash_il_prog_seq
    import fseq_pkg::*;
#(
    parameter int          BLK_W      = 10,
    parameter int          PG_W       = 6,
    parameter int          PAGE_WORDS = 2048,
    parameter logic [15:0] BUF_BASE   = 16'h0200,
    parameter int          TMO_W      = 16,
    localparam int         IW = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_die,
    input  logic [BLK_W-1:0] cmd_block,
    input  logic [PG_W-1:0]  cmd_page,
    input  logic [PG_W:0]    cmd_count,
    input  logic [TMO_W-1:0] poll_limit,
    input  logic             din_valid,
    output logic             din_ready,
    input  logic [15:0]      din_data,
    output logic             bus_en,
    output logic             bus_we,
    output logic [15:0]      bus_addr,
    output logic [15:0]      bus_wdata,
    input  logic [15:0]      bus_rdata,
    output logic             res_done,
    output logic [1:0]       res_code,
    output logic             res_die,
    output logic [PG_W-1:0]  res_page,
    output logic [15:0]      res_status
);
    state_e             state;
    logic               die0, side;
    logic [BLK_W-1:0]   blk;
    logic [PG_W-1:0]    page0;
    logic [PG_W:0]      cnt, pair_idx;
    logic [TMO_W-1:0]   lim;
    logic [IW-1:0]      widx;
    logic               wlast, tmo_hit, st_err;
    err_e               st_code;

    logic               cur_die, last_pair;
    logic [PG_W-1:0]    cur_page;
    logic [15:0]        die_word;

    assign cur_die   = die0 ^ side;
    assign cur_page  = page0 + pair_idx[PG_W-1:0];
    assign last_pair = ({1'b0, pair_idx} + 1'b1) >= {1'b0, cnt};
    assign die_word  = {cur_die, {(15-BLK_W){1'b0}}, blk};

    fseq_word_ctr #(.WORDS(PAGE_WORDS)) u_wctr (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_BSC),
        .adv(state == S_DATA && din_valid),
        .idx(widx), .last(wlast)
    );

    fseq_poll_timer #(.W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_CSEL),
        .tick(state == S_IWT && bus_rdata != V_READY),
        .limit(lim), .expire(tmo_hit)
    );

    fseq_status_eval u_st (.st(bus_rdata), .is_err(st_err), .code(st_code));

    // Sequence state, pair bookkeeping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            die0       <= 1'b0;
            side       <= 1'b0;
            blk        <= '0;
            page0      <= '0;
            cnt        <= '0;
            pair_idx   <= '0;
            lim        <= '0;
            res_code   <= E_OK;
            res_die    <= 1'b0;
            res_page   <= '0;
            res_status <= '0;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid) begin
                    die0     <= cmd_die;
                    blk      <= cmd_block;
                    page0    <= cmd_page;
                    cnt      <= cmd_count;
                    lim      <= poll_limit;
                    pair_idx <= '0;
                    side     <= 1'b0;
                    state    <= S_SEL;
                end
                S_SEL:   state <= S_BSEL;
                S_BSEL:  state <= S_PADDR;
                S_PADDR: state <= S_BSC;
                S_BSC:   state <= S_DATA;
                S_DATA:  if (din_valid && wlast) state <= S_CMD;
                S_CMD: begin
                    side  <= ~side;
                    state <= side ? S_CSEL : S_SEL;
                end
                S_CSEL:  state <= S_IRD;
                S_IRD:   state <= S_IWT;
                S_IWT: begin
                    if (bus_rdata == V_READY) state <= S_SRD;
                    else if (tmo_hit) begin
                        res_code   <= E_TMO;
                        res_die    <= cur_die;
                        res_page   <= cur_page;
                        res_status <= bus_rdata;
                        state      <= S_FIN;
                    end else state <= S_IRD;
                end
                S_SRD:   state <= S_SWT;
                S_SWT: begin
                    if (st_err || (side && last_pair)) begin
                        res_code   <= st_code;
                        res_die    <= cur_die;
                        res_page   <= cur_page;
                        res_status <= bus_rdata;
                        state      <= S_FIN;
                    end else if (!side) begin
                        side  <= 1'b1;
                        state <= S_CSEL;
                    end else begin
                        side     <= 1'b0;
                        pair_idx <= pair_idx + 1'b1;
                        state    <= S_SEL;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Register port and stream handshake decoded from the current state.
    always_comb begin
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        din_ready = 1'b0;
        case (state)
            S_SEL, S_CSEL: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_DIE_BLK; bus_wdata = die_word;
            end
            S_BSEL: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_BUF_SEL; bus_wdata = {cur_die, 15'd0};
            end
            S_PADDR: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_PG_ADDR;
                bus_wdata = {{(14-PG_W){1'b0}}, cur_page, 2'b00};
            end
            S_BSC: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_BSC; bus_wdata = V_BSC;
            end
            S_DATA: begin
                din_ready = 1'b1;
                bus_en    = din_valid; bus_we = 1'b1;
                bus_addr  = BUF_BASE + 16'(widx);
                bus_wdata = din_data;
            end
            S_CMD: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_CMD;
                bus_wdata = last_pair ? V_FINAL : V_CACHE;
            end
            S_IRD: begin bus_en = 1'b1; bus_addr = A_INT;    end
            S_SRD: begin bus_en = 1'b1; bus_addr = A_CTL_ST; end
            default: ;
        endcase
    end

    assign cmd_ready = (state == S_IDLE);
    assign res_done  = (state == S_FIN);

    // ---------------- assertions ----------------
    logic bsel_ok, cmd_odd, wr_dat;
    assign wr_dat = bus_en && bus_we && bus_addr >= BUF_BASE
                    && bus_addr < BUF_BASE + 16'(PAGE_WORDS);

    // Track buffer-select since last die select, and program command parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsel_ok <= 1'b0;
            cmd_odd <= 1'b0;
        end else begin
            if (bus_en && bus_we && bus_addr == A_DIE_BLK) bsel_ok <= 1'b0;
            if (bus_en && bus_we && bus_addr == A_BUF_SEL) bsel_ok <= 1'b1;
            if (bus_en && bus_we && bus_addr == A_CMD)     cmd_odd <= ~cmd_odd;
        end
    end

    assert_bufsel_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dat |-> bsel_ok);
    assert_sector_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == A_PG_ADDR) |-> bus_wdata[1:0] == 2'b00);
    assert_cmd_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == A_CMD) |-> (bus_wdata == V_CACHE || bus_wdata == V_FINAL));
    assert_paired_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> !cmd_odd);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);
    assert_stream_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready && din_valid) |-> wr_dat);
endmodule

// File: tb/tb_flash_il_prog_seq.sv
module tb_flash_il_prog_seq;
    localparam int PW = 4;
    localparam logic [15:0] BB = 16'h0200;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_ready, cmd_die = 1'b0;
    logic [9:0]  cmd_block = '0;
    logic [5:0]  cmd_page = '0;
    logic [6:0]  cmd_count = '0;
    logic [15:0] poll_limit = 16'd100;
    logic        din_valid, din_ready;
    logic [15:0] din_data;
    logic        bus_en, bus_we;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        res_done, res_die;
    logic [1:0]  res_code;
    logic [5:0]  res_page;
    logic [15:0] res_status;

    flash_il_prog_seq #(.PAGE_WORDS(PW), .BUF_BASE(BB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_die(cmd_die), .cmd_block(cmd_block), .cmd_page(cmd_page),
        .cmd_count(cmd_count), .poll_limit(poll_limit), .din_valid(din_valid),
        .din_ready(din_ready), .din_data(din_data), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .res_done(res_done), .res_code(res_code),
        .res_die(res_die), .res_page(res_page), .res_status(res_status)
    );

    int nchk = 0, nfail = 0;

    // Device model configuration (written by the bench only)
    logic        mdl_clr = 1'b0, stall_en = 1'b0;
    int          rd_delay = 0, err_die = -1, err_chk = -1;
    logic [15:0] err_val = '0;

    // Device model state
    logic        mdl_die;
    int          busy [2];
    int          chk_cnt [2];
    int          ntr;
    logic        tr_we [512];
    logic [15:0] tr_addr [512];
    logic [15:0] tr_data [512];

    always @(posedge clk) begin
        if (!rst_n || mdl_clr) begin
            if (!rst_n) begin
                din_data  <= 16'h1000;
                din_valid <= 1'b0;
                bus_rdata <= '0;
            end
            mdl_die <= 1'b0;
            busy[0] <= 0; busy[1] <= 0;
            chk_cnt[0] <= 0; chk_cnt[1] <= 0;
            ntr <= 0;
        end else begin
            din_valid <= stall_en ? ~din_valid : 1'b1;
            if (din_valid && din_ready) din_data <= din_data + 16'd1;
            if (bus_en) begin
                if (ntr < 512) begin
                    tr_we[ntr]   <= bus_we;
                    tr_addr[ntr] <= bus_addr;
                    tr_data[ntr] <= bus_we ? bus_wdata : 16'h0;
                    ntr <= ntr + 1;
                end
                if (bus_we) begin
                    if (bus_addr == 16'hF100) mdl_die <= bus_wdata[15];
                    if (bus_addr == 16'hF220) busy[mdl_die] <= rd_delay;
                end else if (bus_addr == 16'hF241) begin
                    if (busy[mdl_die] > 0) begin
                        busy[mdl_die] <= busy[mdl_die] - 1;
                        bus_rdata <= 16'h0000;
                    end else bus_rdata <= 16'h8040;
                end else if (bus_addr == 16'hF240) begin
                    bus_rdata <= (int'(mdl_die) == err_die && chk_cnt[mdl_die] == err_chk) ? err_val : 16'h0;
                    chk_cnt[mdl_die] <= chk_cnt[mdl_die] + 1;
                end
            end
        end
    end

    // Expected trace
    logic        ex_we [512];
    logic [15:0] ex_addr [512];
    logic [15:0] ex_data [512];
    int          nex;

    task automatic push(input logic we, input logic [15:0] a, input logic [15:0] d);
        if (nex < 512) begin
            ex_we[nex] = we; ex_addr[nex] = a; ex_data[nex] = d;
        end
        nex++;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Run one command against the model and compare everything with the
    // trace and result built here from the requirements.
    task automatic run_case(input string tags, input logic d0, input logic [9:0] blk,
                            input logic [5:0] fp, input logic [6:0] cnt, input int delay,
                            input logic [15:0] lim, input int edie, input int echk,
                            input logic [15:0] ev, input bit stall);
        int pairs, words, wd, xdie, xpage;
        logic [15:0] ds, w, xst;
        logic [1:0] xcode;
        bit stop, got, tr_ok;
        int bad;
        // configure model
        @(negedge clk);
        rd_delay = delay; err_die = edie; err_chk = echk; err_val = ev; stall_en = stall;
        mdl_clr = 1'b1;
        @(negedge clk);
        mdl_clr = 1'b0;
        ds = din_data;
        // expected trace
        nex = 0; w = ds; words = 0; stop = 0;
        xcode = 0; xdie = 0; xpage = 0; xst = 0;
        pairs = (cnt == 0) ? 1 : int'(cnt);
        for (int k = 0; k < pairs && !stop; k++) begin
            logic [5:0] p;
            p = fp + 6'(k);
            for (int s = 0; s < 2; s++) begin
                logic d;
                d = d0 ^ s[0];
                push(1, 16'hF100, {d, 5'd0, blk});
                push(1, 16'hF101, {d, 15'd0});
                push(1, 16'hF107, {8'd0, p, 2'b00});
                push(1, 16'hF200, 16'h0800);
                for (int i = 0; i < PW; i++) begin
                    push(1, BB + 16'(i), w); w++; words++;
                end
                push(1, 16'hF220, (k == pairs - 1) ? 16'h0080 : 16'h007F);
            end
            for (int s = 0; s < 2 && !stop; s++) begin
                logic d;
                d = d0 ^ s[0];
                push(1, 16'hF100, {d, 5'd0, blk});
                xdie = int'(d); xpage = int'(p);
                if (delay >= ((lim == 0) ? 1 : int'(lim))) begin
                    for (int r = 0; r < ((lim == 0) ? 1 : int'(lim)); r++) push(0, 16'hF241, 0);
                    xcode = 3; xst = 0; stop = 1;
                end else begin
                    for (int r = 0; r <= delay; r++) push(0, 16'hF241, 0);
                    push(0, 16'hF240, 0);
                    if (int'(d) == edie && k == echk) begin
                        xcode = ev[2] ? 2'd2 : 2'd1; xst = ev; stop = 1;
                    end
                end
            end
        end
        // issue command
        cmd_die = d0; cmd_block = blk; cmd_page = fp; cmd_count = cnt; poll_limit = lim;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R11", "cmd_ready busy", 32'(cmd_ready), 0);
        got = 0;
        for (wd = 0; wd < 20000 && !got; wd++) begin
            @(negedge clk);
            if (res_done) got = 1;
        end
        check(got, tags, "watchdog done", 32'(got), 1);
        if (got) begin
            check(res_code == xcode && res_status == xst, tags, "code/status",
                  {14'd0, res_code, res_status}, {14'd0, xcode, xst});
            if (xcode != 0)
                check(int'(res_die) == xdie && int'(res_page) == xpage, "R8", "die/page",
                      32'({res_die, res_page}), 32'({xdie[0], xpage[5:0]}));
            @(negedge clk);
            check(res_done == 1'b0 && cmd_ready == 1'b1, "R11", "done pulse/ready",
                  32'({res_done, cmd_ready}), 32'b01);
        end
        // trace compare: R2 R3 R4 R5 R6 R7
        tr_ok = (ntr == nex); bad = -1;
        for (int i = 0; i < nex && i < 512 && tr_ok; i++)
            if (tr_we[i] !== ex_we[i] || tr_addr[i] !== ex_addr[i] || tr_data[i] !== ex_data[i]) begin
                tr_ok = 0; bad = i;
            end
        if (bad >= 0)
            check(0, "R2/R3/R4/R5/R7", $sformatf("trace entry %0d", bad),
                  {15'd0, tr_we[bad], tr_addr[bad]}, {15'd0, ex_we[bad], ex_addr[bad]});
        else
            check(tr_ok, "R2 R3 R4 R5 R6 R7", "trace length", 32'(ntr), 32'(nex));
        check(int'(din_data - ds) == words, "R3", "words consumed", 32'(din_data - ds), 32'(words));
    endtask

    task automatic t_reset();
        check(cmd_ready == 1'b1, "R1", "cmd_ready", 32'(cmd_ready), 1);
        check(res_done == 1'b0, "R1", "res_done", 32'(res_done), 0);
        check(din_ready == 1'b0, "R1", "din_ready", 32'(din_ready), 0);
        check(bus_en == 1'b0, "R1", "bus_en", 32'(bus_en), 0);
    endtask

    // R4 R10: one page per die, final command only
    task automatic t_single();  run_case("R10", 0, 10'h155, 6'd3, 7'd1, 0, 16'd50, -1, -1, 0, 0); endtask
    // R5 R7: three pairs, second die first, busy polls, stalled stream
    task automatic t_multi();   run_case("R10", 1, 10'h002, 6'd10, 7'd3, 2, 16'd50, -1, -1, 0, 1); endtask
    // R8: previous-op error on second die of the middle pair
    task automatic t_prev();    run_case("R8", 0, 10'h03C, 6'd20, 7'd3, 1, 16'd50, 1, 1, 16'h0004, 0); endtask
    // R8 R6: program error on the first-checked die of pair 0
    task automatic t_prog();    run_case("R8", 1, 10'h201, 6'd0, 7'd2, 0, 16'd50, 1, 0, 16'h0400, 0); endtask
    // R8: bit 4 only counts as a current error
    task automatic t_bit4();    run_case("R8", 1, 10'h011, 6'd5, 7'd2, 0, 16'd50, 0, 1, 16'h0010, 0); endtask
    // R9: interrupt never ready
    task automatic t_timeout(); run_case("R9", 0, 10'h0AA, 6'd7, 7'd2, 1000, 16'd5, -1, -1, 0, 0); endtask
    // R4: count zero acts as one
    task automatic t_zero();    run_case("R4", 1, 10'h3FF, 6'd63, 7'd0, 0, 16'd50, -1, -1, 0, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_prev();
        t_prog();
        t_bit4();
        t_timeout();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1000000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule